// File: doc/BRIEF.md
# UART Interrupt Masking and Identification

This block decides whether one UART channel should raise its interrupt, and tells software why. Five condition inputs come from elsewhere in the channel:

- receiver line status,
- received data available,
- receiver character timeout,
- transmit holding register empty,
- modem status.

A byte-wide enable register, written over a simple write strobe, selects which conditions may reach the interrupt. The block drives one active-high interrupt output. It also drives an identification byte that names the most urgent enabled pending condition and shows whether FIFO mode is active.

Masking only hides a condition. It never clears or blocks the condition itself. A condition that was pending while masked therefore shows up as soon as its enable bit is set. The identification byte and the interrupt output are both registered. Each reflects the enable register and the condition inputs as they stood at the previous clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Enable bit 0 admits the received-data-available condition. When FIFO mode is on, the same bit also admits the character-timeout condition. Outside FIFO mode the timeout input is ignored.
- R2: Enable bit 1 admits the transmit-holding-empty condition.
- R3: Enable bit 2 admits the receiver line status condition.
- R4: Enable bit 3 admits the modem status condition.
- R5: A write stores bits 3:0 of the data. The enable readback shows the new value one cycle after the write strobe. Readback bits 7:4 are always 0.
- R6: A condition whose enable bit is 0 never appears in the identification byte and never raises the interrupt output.
- R7: Masking does not discard a condition. If a condition is still active when its enable bit gets set, it is reported on the cycle after the new enable value appears.
- R8: Priority runs from highest to lowest, with identification bits 3:0 coded as follows:
  - line status: 0110
  - data available: 0100
  - character timeout: 1100
  - transmit holding empty: 0010
  - modem status: 0000
- R9: Identification bits 7 and 6 both equal the FIFO mode input sampled at the previous edge. Bits 5 and 4 read 0.
- R10: When no enabled condition is pending, identification bits 3:0 read 0001 and the interrupt output is low. The interrupt output falls on the cycle after the last enabled condition clears.
- R11: While reset is active, the enable register is cleared. After reset the enable readback is 0x00, the identification byte is 0x01 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Write data for the enable register |
| fifo_mode | input | 1 | FIFO mode active |
| src_line | input | 1 | Receiver line status condition |
| src_rxdata | input | 1 | Received data available condition |
| src_rxtmo | input | 1 | Receiver character timeout condition |
| src_thre | input | 1 | Transmit holding register empty condition |
| src_modem | input | 1 | Modem status condition |
| en_rdata | output | 8 | Enable register readback |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt output, active high |

## Verification
Each result has its own latency:

- A write strobe changes the enable readback one clock later.
- A change on a condition input or on the FIFO mode input shows in the identification byte and the interrupt output one clock later.
- A new enable value therefore reaches the identification byte two clocks after its write strobe.

The bench drives inputs on the falling edge and samples one rising edge later. It compares the enable readback against the updated model. It compares the identification byte and the interrupt against a model built from the enable value that was in force before that edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned CODE_W  = 4;

  // Order of pending conditions, index 0 is the most urgent.
  typedef enum logic [2:0] {
    SRC_LINE   = 3'd0,
    SRC_RXDATA = 3'd1,
    SRC_RXTMO  = 3'd2,
    SRC_THRE   = 3'd3,
    SRC_MODEM  = 3'd4
  } irq_src_e;

  localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

  function automatic logic [CODE_W-1:0] src_code(input int unsigned idx);
    case (idx)
      0:       return 4'b0110;
      1:       return 4'b0100;
      2:       return 4'b1100;
      3:       return 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en_q
);
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:EN_W];

  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (wr) en_q <= wdata[EN_W-1:0];
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0]      req,
  output logic [CODE_W-1:0] code,
  output logic              any
);
  // Walk from lowest priority up so the most urgent request wins.
  always_comb begin
    code = CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = src_code(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              any,
  input  logic              fifo_mode,
  output logic [DATA_W-1:0] ident_q,
  output logic              irq_q
);
  localparam int unsigned PAD_W = DATA_W - CODE_W - 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ident_q <= DATA_W'(CODE_NONE);
      irq_q   <= 1'b0;
    end else begin
      ident_q <= {{2{fifo_mode}}, {PAD_W{1'b0}}, code};
      irq_q   <= any;
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] en_wdata,
  input  logic              fifo_mode,
  input  logic              src_line,
  input  logic              src_rxdata,
  input  logic              src_rxtmo,
  input  logic              src_thre,
  input  logic              src_modem,
  output logic [DATA_W-1:0] en_rdata,
  output logic              irq,
  output logic [DATA_W-1:0] ident
);
  logic [EN_W-1:0]    en_q;
  logic [NUM_SRC-1:0] req;
  logic [CODE_W-1:0]  code;
  logic               any;

  irq_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_en (
    .clk(clk), .rst(rst), .wr(en_wr), .wdata(en_wdata), .en_q(en_q)
  );

  // Masked requests in priority order.
  assign req[SRC_LINE]   = src_line   & en_q[2];
  assign req[SRC_RXDATA] = src_rxdata & en_q[0];
  assign req[SRC_RXTMO]  = src_rxtmo  & en_q[0] & fifo_mode;
  assign req[SRC_THRE]   = src_thre   & en_q[1];
  assign req[SRC_MODEM]  = src_modem  & en_q[3];

  irq_prio_sel #(.N(NUM_SRC)) u_sel (
    .req(req), .code(code), .any(any)
  );

  irq_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .code(code), .any(any), .fifo_mode(fifo_mode),
    .ident_q(ident), .irq_q(irq)
  );

  assign en_rdata = {{(DATA_W-EN_W){1'b0}}, en_q};
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_mode,
  input logic              src_line,
  input logic [DATA_W-1:0] en_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] ident
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (en_rdata == '0 && ident == DATA_W'(1) && !irq)); // R11

  AST_EN_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    en_rdata[DATA_W-1:4] == '0); // R5

  AST_IRQ_VS_IDENT: assert property (@(posedge clk) disable iff (rst)
    irq == !ident[0]); // R10

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en_rdata == '0) |=> (!irq && ident[3:0] == 4'b0001)); // R6

  AST_FIFO_BITS: assert property (@(posedge clk) disable iff (rst)
    seen |-> ident[7:6] == {2{$past(fifo_mode)}}); // R9

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (src_line && en_rdata[2]) |=> (ident[3:0] == 4'b0110)); // R3
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .src_line(src_line),
  .en_rdata(en_rdata), .irq(irq), .ident(ident)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 1'b0;
  logic [7:0] en_wdata = '0;
  logic fifo_mode = 1'b0;
  logic s_ls = 1'b0, s_rd = 1'b0, s_to = 1'b0, s_th = 1'b0, s_ms = 1'b0;
  logic [7:0] en_rdata, ident;
  logic irq;
  int n_run = 0, n_fail = 0;
  logic [3:0] en_m = '0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .fifo_mode(fifo_mode), .src_line(s_ls), .src_rxdata(s_rd),
    .src_rxtmo(s_to), .src_thre(s_th), .src_modem(s_ms),
    .en_rdata(en_rdata), .irq(irq), .ident(ident)
  );

  function automatic logic [7:0] exp_ident(input logic [3:0] en, input logic fm,
      input logic ls, input logic rd, input logic to, input logic th, input logic ms);
    logic [3:0] c;
    if (ls && en[2])            c = 4'b0110;
    else if (rd && en[0])       c = 4'b0100;
    else if (to && en[0] && fm) c = 4'b1100;
    else if (th && en[1])       c = 4'b0010;
    else if (ms && en[3])       c = 4'b0000;
    else                        c = 4'b0001;
    return {fm, fm, 2'b00, c};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_src(input logic fm, input logic [4:0] s);
    fifo_mode = fm; {s_ls, s_rd, s_to, s_th, s_ms} = s;
  endtask

  task automatic wr_en(input logic [7:0] d);
    en_wr = 1'b1; en_wdata = d; step(); en_wr = 1'b0; en_m = d[3:0];
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0; step();
    chk("R11 en", en_rdata, 8'h00);
    chk("R11 ident", ident, 8'h01);
    chk("R11 irq", {7'b0, irq}, 8'h00);

    wr_en(8'hFF);
    chk("R5 readback", en_rdata, 8'h0F);
    set_src(1'b0, 5'b11111); step();
    chk("R3 line first", ident, 8'h06);
    chk("R8 irq on", {7'b0, irq}, 8'h01);

    wr_en(8'h01); set_src(1'b1, 5'b00100); step();
    chk("R1 timeout fifo", ident, 8'hCC);
    set_src(1'b0, 5'b00100); step();
    chk("R1 timeout ignored", ident, 8'h01);
    set_src(1'b1, 5'b01100); step();
    chk("R8 data over timeout", ident, 8'hC4);

    wr_en(8'h02); set_src(1'b0, 5'b00011); step();
    chk("R2 thre", ident, 8'h02);
    wr_en(8'h08); step();
    chk("R4 modem", ident, 8'h00);
    chk("R4 irq", {7'b0, irq}, 8'h01);

    wr_en(8'hF0); set_src(1'b0, 5'b11111); step();
    chk("R6 masked ident", ident, 8'h01);
    chk("R6 masked irq", {7'b0, irq}, 8'h00);
    chk("R5 high bits", en_rdata, 8'h00);

    set_src(1'b0, 5'b10000); step();
    wr_en(8'h04);
    chk("R7 not yet", ident, 8'h01);
    step();
    chk("R7 retained", ident, 8'h06);
    set_src(1'b0, 5'b00000); step();
    chk("R10 none", ident, 8'h01);
    chk("R10 irq off", {7'b0, irq}, 8'h00);
    set_src(1'b1, 5'b00000); step();
    chk("R9 fifo bits", ident, 8'hC1);

    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      logic [3:0] en_old;
      logic [7:0] e;
      en_old = en_m;
      en_wr = ($urandom % 4) == 0;
      en_wdata = 8'($urandom);
      fifo_mode = 1'($urandom);
      {s_ls, s_rd, s_to, s_th, s_ms} = 5'($urandom);
      if (en_wr) en_m = en_wdata[3:0];
      e = exp_ident(en_old, fifo_mode, s_ls, s_rd, s_to, s_th, s_ms);
      step();
      chk("R5 rand readback", en_rdata, {4'b0, en_m});
      chk("R8 rand ident", ident, e);
      chk("R10 rand irq", {7'b0, irq}, {7'b0, ~e[0]});
    end
    en_wr = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule